// File: doc/BRIEF.md
# Parallel NOR Flash Status Register Interface

This block is the command-side status logic of a parallel NOR flash device. It watches the bus control pins (chip enable, output enable, write enable, address valid) together with a command byte, an address and a burst-mode flag. From these it decodes commands and keeps an 8-bit status register. A small operation-timer stub stands in for program, erase and lock operations: each one holds the device busy for a fixed number of clock cycles. On a read, the block returns either the captured status or a placeholder array word.

The read mode is either array or status. Reset selects array mode. A read-status command switches to status mode. So does the first cycle of any program, erase or lock sequence, so software can poll for completion without issuing a read-status command. Status mode lasts until a read-array command is written. Error bits are sticky: once set, they stay set until a clear-status command or a reset. A test input injects the error conditions that a finishing operation reports.

The status value on the data pins is a captured copy of the live register, not the live register itself. In asynchronous mode the copy is taken at the start of each read. In burst mode it refreshes only when chip enable or address valid falls.

All pins are sampled on the rising edge of `clk`. A pin event is a difference between the current sample and the previous one.

Top module: `nor_status_ctrl`

## Requirements
- R1: While `ceN` and `oeN` are both low in status mode, `dataOut[7:0]` is the captured status and `dataOut[15:8]` is 0x00. In array mode the same read returns `ARRAY_FILL` XOR every 16-bit slice of the zero-padded address. With `ceN` or `oeN` high, `dataOut` is 0x0000.
- R2: A command is taken when `weN` is sampled rising while `ceN` is low, and `cmdByte` carries the command. 0x70 selects status mode at any address, and 0xFF selects array mode.
- R3: Three sequences each start an operation and leave status mode selected with no 0x70 needed. They are 0x40 followed by any byte, 0x20 followed by 0xD0, and 0x60 followed by 0x01. The first write of each sequence already selects status mode.
- R4: Once selected, status mode persists through every command other than 0xFF, including 0x50 and further 0x70 writes.
- R5: Status bit 7 (ready) is 0 for exactly `BUSY_CYCLES` clock cycles after the edge that starts an operation, and 1 otherwise. Writes taken while it is 0 have no effect.
- R6: The edge on which an operation finishes ORs in four error bits:
  - `errInject[0]` into bit 1 (locked);
  - `vppLow` into bit 3 (programming voltage);
  - `errInject[1]` into bit 4 (program);
  - `errInject[2]` into bit 5 (erase).
  Bits 6, 2 and 0 always read 0.
- R7: Bits 5, 4, 3 and 1 stay set until a 0x50 command or a reset clears them. The 0x50 command clears them even while `vppLow` is high.
- R8: If the second write of an erase sequence is not 0xD0, or the second write of a lock sequence is not 0x01, the sequence is dropped. No operation starts, bits 5 and 4 are set, and status mode is selected.
- R9: With `burstMode` low, the status is captured on the first falling edge of `ceN` or `oeN`. A later fall of the other pin does not update it. Capture is re-armed when either pin rises.
- R10: With `burstMode` high, the captured status refreshes only on a falling edge of `ceN` or `advN`. An `oeN` fall does not refresh it.
- R11: After reset the device is in array mode with no sequence pending, and the status is 0x80 (ready, no errors).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low; the command is taken when it rises |
| advN | input | 1 | Address valid, active low; its fall refreshes status in burst mode |
| burstMode | input | 1 | 1 selects synchronous burst read behaviour |
| addr | input | ADDR_W | Bus address, used only for the array placeholder |
| cmdByte | input | 8 | Command or data byte written |
| errInject | input | 3 | Test errors applied when an operation finishes: [0] locked, [1] program, [2] erase |
| vppLow | input | 1 | Programming voltage out of range, reported when an operation finishes |
| dataOut | output | 16 | Read data |

## Verification
The assertions assume that every pin is synchronous to `clk` and holds each value for at least one cycle. They also assume that `ceN` and `oeN` never move in opposite directions on the same edge, and that `burstMode` changes only while `ceN` is high. The bench drives all pins one time unit after the rising edge. It changes one pin at a time, except that it lowers `ceN` and `oeN` together to open a read. It flips `burstMode` only between accesses, with `ceN` high.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PROG  = 2'd1,
    PH_ERASE = 2'd2,
    PH_LOCK  = 2'd3
  } phase_e;

  // Strobes and levels passed from control to datapath
  typedef struct packed {
    logic statusMode;  // read mode: 1 = status, 0 = array
    logic busy;        // operation timer running
    logic opDone;      // operation finishes on this edge
    logic clrErr;      // clear-status command taken
    logic seqErr;      // two-cycle sequence dropped
  } ctrlStrobes_t;

  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR       = 8'h50;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_PROGRAM     = 8'h40;
  localparam logic [7:0] OP_ERASE       = 8'h20;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_LOCK        = 8'h60;
  localparam logic [7:0] OP_LOCK_GO     = 8'h01;

  localparam int SR_W   = 8;
  localparam int ERR_W  = 4;
  localparam int DATA_W = 16;

  // errBits order: [3] erase (SR5), [2] program (SR4), [1] voltage (SR3), [0] locked (SR1)
  function automatic logic [SR_W-1:0] packStatus(input logic ready, input logic [ERR_W-1:0] err);
    return {ready, 1'b0, err[3], err[2], err[1], 1'b0, err[0], 1'b0};
  endfunction

endpackage

// File: rtl/nsc_control.sv
module nsc_control
  import nsc_pkg::*;
#(
  parameter int BUSY_CYCLES = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         weN,
  input  logic [7:0]   cmdByte,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             weNq;
  logic             wrStb;
  phase_e           phase, phaseNext;
  logic             statusMode, modeNext;
  logic [CNT_W-1:0] busyCnt;
  logic             busy, opStart, opDone, clrErr, seqErr;

  // Write strobe: WE# sampled rising while CE# is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weNq <= 1'b1;
    else       weNq <= weN;
  end

  assign wrStb  = ~ceN & weN & ~weNq;
  assign busy   = (busyCnt != '0);
  assign opDone = (busyCnt == CNT_ONE);

  // Command decoder
  always_comb begin
    phaseNext = phase;
    modeNext  = statusMode;
    opStart   = 1'b0;
    clrErr    = 1'b0;
    seqErr    = 1'b0;
    if (wrStb && !busy) begin
      unique case (phase)
        PH_IDLE: begin
          case (cmdByte)
            OP_READ_STATUS: modeNext = 1'b1;
            OP_READ_ARRAY:  modeNext = 1'b0;
            OP_CLEAR:       clrErr   = 1'b1;
            OP_PROGRAM: begin
              phaseNext = PH_PROG;
              modeNext  = 1'b1;
            end
            OP_ERASE: begin
              phaseNext = PH_ERASE;
              modeNext  = 1'b1;
            end
            OP_LOCK: begin
              phaseNext = PH_LOCK;
              modeNext  = 1'b1;
            end
            default: ;
          endcase
        end
        PH_PROG: begin
          opStart   = 1'b1;
          phaseNext = PH_IDLE;
          modeNext  = 1'b1;
        end
        PH_ERASE: begin
          opStart   = (cmdByte == OP_ERASE_GO);
          seqErr    = (cmdByte != OP_ERASE_GO);
          phaseNext = PH_IDLE;
          modeNext  = 1'b1;
        end
        PH_LOCK: begin
          opStart   = (cmdByte == OP_LOCK_GO);
          seqErr    = (cmdByte != OP_LOCK_GO);
          phaseNext = PH_IDLE;
          modeNext  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      statusMode <= 1'b0;
    end else begin
      phase      <= phaseNext;
      statusMode <= modeNext;
    end
  end

  // Operation timer stub
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busyCnt <= '0;
    else if (opStart) busyCnt <= CNT_LOAD;
    else if (busy)    busyCnt <= busyCnt - CNT_ONE;
  end

  assign strobes = '{statusMode: statusMode, busy: busy, opDone: opDone,
                     clrErr: clrErr, seqErr: seqErr};

  // R5: a write taken while busy leaves mode and sequence untouched
  a_r5_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrStb) |=> ($stable(statusMode) && $stable(phase)));

  // R3: starting an operation leaves status mode selected and the device busy
  a_r3_auto_status: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> (statusMode && busy));

  // R4: only a read-array command can leave status mode
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (statusMode && !(wrStb && !busy && phase == PH_IDLE && cmdByte == OP_READ_ARRAY))
      |=> statusMode);

endmodule

// File: rtl/nsc_datapath.sv
module nsc_datapath
  import nsc_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter logic [15:0] ARRAY_FILL = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              advN,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        errInject,
  input  logic              vppLow,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] dataOut
);

  localparam int CHUNKS = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W  = CHUNKS * DATA_W;

  logic             ceNq, oeNq, advNq, armed;
  logic             ceFell, oeFell, advFell, ceRose, oeRose;
  logic             capAsync, capBurst;
  logic [SR_W-1:0]  liveSr, capSr;
  logic [ERR_W-1:0] errBits, errNext;

  // Pin history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceNq  <= 1'b1;
      oeNq  <= 1'b1;
      advNq <= 1'b1;
    end else begin
      ceNq  <= ceN;
      oeNq  <= oeN;
      advNq <= advN;
    end
  end

  assign ceFell  = ~ceN & ceNq;
  assign oeFell  = ~oeN & oeNq;
  assign advFell = ~advN & advNq;
  assign ceRose  = ceN & ~ceNq;
  assign oeRose  = oeN & ~oeNq;

  // Capture events: first CE#/OE# fall per read (async), CE#/ADV# fall (burst)
  assign capAsync = ~burstMode & armed & (ceFell | oeFell);
  assign capBurst = burstMode & (ceFell | advFell);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  armed <= 1'b1;
    else if (capAsync)          armed <= 1'b0;
    else if (ceRose || oeRose)  armed <= 1'b1;
  end

  // Sticky error bits
  always_comb begin
    errNext = errBits;
    if (strobes.clrErr) errNext = '0;
    if (strobes.seqErr) errNext = errNext | 4'b1100;
    if (strobes.opDone) errNext = errNext | {errInject[2], errInject[1], vppLow, errInject[0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errBits <= '0;
    else       errBits <= errNext;
  end

  assign liveSr = packStatus(~strobes.busy, errBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    capSr <= packStatus(1'b1, '0);
    else if (capAsync || capBurst) capSr <= liveSr;
  end

  // Array placeholder: fill word folded with every 16-bit slice of the address
  logic [PAD_W-1:0]  addrPad;
  logic [DATA_W-1:0] foldAcc [CHUNKS+1];

  assign addrPad    = PAD_W'(addr);
  assign foldAcc[0] = ARRAY_FILL;

  for (genvar g = 0; g < CHUNKS; g++) begin : g_fold
    assign foldAcc[g+1] = foldAcc[g] ^ addrPad[g*DATA_W +: DATA_W];
  end

  always_comb begin
    if (ceN || oeN)              dataOut = '0;
    else if (strobes.statusMode) dataOut = {8'h00, capSr};
    else                         dataOut = foldAcc[CHUNKS];
  end

  // R1: upper byte reads zero during a status read
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && strobes.statusMode) |-> (dataOut[15:8] == 8'h00));

  // R7: error bits never drop without a clear command
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clrErr |=> ((errBits & $past(errBits)) == $past(errBits)));

  // R7: a clear command empties the error bits
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrErr |=> (errBits == '0));

  // R6: an injected program error is reported when the operation finishes
  a_r6_prog_err: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.opDone && errInject[1]) |=> errBits[2]);

  // R9: once captured in async mode, no refresh until re-armed
  a_r9_async_once: assert property (@(posedge clk) disable iff (!rstN)
    (!burstMode && !armed) |=> $stable(capSr));

  // R10: burst mode refreshes only on CE# or ADV# fall
  a_r10_burst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (burstMode && !ceFell && !advFell) |=> $stable(capSr));

endmodule

// File: rtl/nor_status_ctrl.sv
module nor_status_ctrl
  import nsc_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          BUSY_CYCLES = 12,
  parameter logic [15:0] ARRAY_FILL  = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              advN,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmdByte,
  input  logic [2:0]        errInject,
  input  logic              vppLow,
  output logic [15:0]       dataOut
);

  ctrlStrobes_t strobes;

  nsc_control #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .weN     (weN),
    .cmdByte (cmdByte),
    .strobes (strobes)
  );

  nsc_datapath #(
    .ADDR_W     (ADDR_W),
    .ARRAY_FILL (ARRAY_FILL)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .oeN       (oeN),
    .advN      (advN),
    .burstMode (burstMode),
    .addr      (addr),
    .errInject (errInject),
    .vppLow    (vppLow),
    .strobes   (strobes),
    .dataOut   (dataOut)
  );

endmodule

// File: tb/nor_status_ctrl_bench.sv
module nor_status_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int BUSY       = 12;
  localparam logic [15:0] FILL = 16'hA5C3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, weN = 1'b1, advN = 1'b1;
  logic              burstMode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        cmdByte = 8'h00;
  logic [2:0]        errInject = 3'b000;
  logic              vppLow = 1'b0;
  logic [15:0]       dataOut;

  int    nChecks = 0;
  int    nFail = 0;
  string reqTag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_status_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY), .ARRAY_FILL(FILL)) u_nor_status_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .advN(advN),
    .burstMode(burstMode), .addr(addr), .cmdByte(cmdByte), .errInject(errInject),
    .vppLow(vppLow), .dataOut(dataOut)
  );

  // ---------------- behavioural reference model ----------------
  bit       mMode, mArmed, pCe, pOe, pWe, pAdv;
  int       mPhase, mCnt;
  bit [3:0] mErr;
  bit [7:0] mCap, live;
  bit       wr, fCe, fOe, fAdv;

  function automatic logic [15:0] foldAddr(input logic [ADDR_W-1:0] a);
    logic [15:0] acc = FILL;
    for (int i = 0; i < ADDR_W; i += 16) begin
      logic [15:0] slice = '0;
      for (int b = 0; b < 16; b++) if (i + b < ADDR_W) slice[b] = a[i+b];
      acc ^= slice;
    end
    return acc;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mPhase = 0; mCnt = 0; mErr = 0; mCap = 8'h80; mArmed = 1;
      pCe = 1; pOe = 1; pWe = 1; pAdv = 1;
    end else begin
      wr   = !ceN && weN && !pWe;
      fCe  = !ceN && pCe;
      fOe  = !oeN && pOe;
      fAdv = !advN && pAdv;
      live = {mCnt == 0, 1'b0, mErr[3], mErr[2], mErr[1], 1'b0, mErr[0], 1'b0};
      if (!burstMode && mArmed && (fCe || fOe)) begin
        mCap = live; mArmed = 0;
      end else if ((ceN && !pCe) || (oeN && !pOe)) mArmed = 1;
      if (burstMode && (fCe || fAdv)) mCap = live;
      if (mCnt > 0) begin
        if (mCnt == 1) mErr = mErr | {errInject[2], errInject[1], vppLow, errInject[0]};
        mCnt = mCnt - 1;
      end else if (wr) begin
        if (mPhase == 0) begin
          case (cmdByte)
            8'h70: mMode = 1;
            8'hFF: mMode = 0;
            8'h50: mErr = 0;
            8'h40: begin mPhase = 1; mMode = 1; end
            8'h20: begin mPhase = 2; mMode = 1; end
            8'h60: begin mPhase = 3; mMode = 1; end
            default: ;
          endcase
        end else begin
          if (mPhase == 1 || (mPhase == 2 && cmdByte == 8'hD0) || (mPhase == 3 && cmdByte == 8'h01))
            mCnt = BUSY;
          else
            mErr = mErr | 4'b1100;
          mPhase = 0; mMode = 1;
        end
      end
      pCe = ceN; pOe = oeN; pWe = weN; pAdv = advN;
    end
  end

  function automatic logic [15:0] modelOut();
    if (ceN || oeN) return 16'h0000;
    if (mMode) return {8'h00, mCap};
    return foldAddr(addr);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: dataOut=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (rstN) check(reqTag, dataOut, modelOut());

  // ---------------- stimulus helpers ----------------
  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busWrite(input logic [7:0] c, input logic [ADDR_W-1:0] a);
    @(posedge clk); #1 ceN = 0; weN = 0; cmdByte = c; addr = a;
    @(posedge clk); #1 weN = 1;
    @(posedge clk); #1 ceN = 1;
  endtask

  task automatic readWord(input string req, input logic [ADDR_W-1:0] a, input logic [15:0] exp);
    @(posedge clk); #1 ceN = 0; oeN = 0; addr = a;
    @(posedge clk);
    @(negedge clk); check(req, dataOut, exp);
    @(posedge clk); #1 ceN = 1; oeN = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    waitCycles(3);
    #1 rstN = 1;
    @(negedge clk); check("R1", dataOut, 16'h0000);             // idle bus
    reqTag = "R11";
    readWord("R11", 24'h123456, 16'h9187);                      // array after reset, R1 placeholder
    reqTag = "R2";
    busWrite(8'h70, 24'hABCDEF);
    readWord("R11", 24'h000000, 16'h0080);                      // reset status
    readWord("R2", 24'h777777, 16'h0080);                       // status at any address
    busWrite(8'hFF, 24'h000010);
    readWord("R2", 24'h123456, 16'h9187);                       // back to array

    reqTag = "R3";
    busWrite(8'h40, 24'h000100); busWrite(8'h5A, 24'h000100);
    readWord("R3", 24'h000100, 16'h0000);                       // status, busy
    waitCycles(BUSY + 3);
    readWord("R3", 24'h000100, 16'h0080);

    reqTag = "R5";                                              // exact busy window
    busWrite(8'h40, 0); busWrite(8'h11, 0);
    waitCycles(BUSY - 2);
    readWord("R5", 0, 16'h0000);                                // captured on last busy edge
    waitCycles(BUSY + 3);
    busWrite(8'h40, 0); busWrite(8'h22, 0);
    waitCycles(BUSY - 1);
    readWord("R5", 0, 16'h0080);                                // captured on first ready edge
    busWrite(8'h40, 0); busWrite(8'h33, 0);
    busWrite(8'hFF, 0);                                         // ignored while busy
    waitCycles(BUSY + 3);
    readWord("R5", 24'h123456, 16'h0080);

    reqTag = "R6";
    errInject = 3'b010;
    busWrite(8'h40, 0); busWrite(8'h44, 0);
    waitCycles(BUSY + 3);
    errInject = 3'b000;
    readWord("R6", 0, 16'h0090);
    reqTag = "R7";
    busWrite(8'h70, 24'h000555);
    readWord("R7", 0, 16'h0090);                                // still set
    reqTag = "R4";
    readWord("R4", 24'h123456, 16'h0090);                       // 0x70 stays in status
    reqTag = "R7";
    vppLow = 1;
    busWrite(8'h50, 0);
    vppLow = 0;
    readWord("R7", 0, 16'h0080);                                // cleared despite vppLow
    readWord("R4", 24'h123456, 16'h0080);                       // 0x50 keeps status mode

    reqTag = "R6";
    busWrite(8'hFF, 0);
    vppLow = 1; errInject = 3'b100;
    busWrite(8'h20, 0); busWrite(8'hD0, 0);
    waitCycles(BUSY + 3);
    vppLow = 0; errInject = 3'b000;
    readWord("R6", 0, 16'h00A8);                                // bits 7,5,3; R3 erase auto status
    busWrite(8'h50, 0);
    errInject = 3'b001;
    busWrite(8'h60, 0); busWrite(8'h01, 0);
    waitCycles(BUSY + 3);
    errInject = 3'b000;
    readWord("R6", 0, 16'h0082);                                // locked bit
    busWrite(8'h50, 0);

    reqTag = "R8";
    busWrite(8'h20, 0); busWrite(8'h33, 0);
    readWord("R8", 0, 16'h00B0);                                // no busy, bits 5 and 4
    busWrite(8'h50, 0);
    busWrite(8'h60, 0); busWrite(8'hD0, 0);
    readWord("R8", 0, 16'h00B0);
    busWrite(8'h50, 0);
    readWord("R8", 0, 16'h0080);

    reqTag = "R9";
    busWrite(8'h40, 0); busWrite(8'h66, 0);
    @(posedge clk); #1 ceN = 0;                                 // first fall captures busy
    waitCycles(BUSY + 2);
    @(posedge clk); #1 oeN = 0;                                 // later OE# fall: no update
    @(posedge clk);
    @(negedge clk); check("R9", dataOut, 16'h0000);
    @(posedge clk); #1 oeN = 1;
    @(posedge clk); #1 oeN = 0;                                 // re-armed by OE# rise
    @(posedge clk);
    @(negedge clk); check("R9", dataOut, 16'h0080);
    @(posedge clk); #1 oeN = 1; ceN = 1;

    reqTag = "R10";
    @(posedge clk); #1 burstMode = 1;
    busWrite(8'h40, 0); busWrite(8'h77, 0);
    @(posedge clk); #1 ceN = 0; advN = 0;                       // captures busy
    waitCycles(BUSY + 2);
    @(posedge clk); #1 oeN = 0;
    @(posedge clk); #1 oeN = 1;
    @(posedge clk); #1 oeN = 0;                                 // OE# toggles do not refresh
    @(posedge clk);
    @(negedge clk); check("R10", dataOut, 16'h0000);
    @(posedge clk); #1 advN = 1;
    @(posedge clk); #1 advN = 0;                                // ADV# fall refreshes
    @(posedge clk);
    @(negedge clk); check("R10", dataOut, 16'h0080);
    @(posedge clk); #1 oeN = 1; advN = 1; ceN = 1;
    @(posedge clk); #1 burstMode = 0;

    reqTag = "R1";
    busWrite(8'hFF, 0);
    readWord("R1", 24'hFFFFFF, foldAddr(24'hFFFFFF));
    waitCycles(4);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule